// File: doc/BRIEF.md
# Ping-Pong Sample Memory Readout Sequencer

This controller sits between a photodetector trigger unit, two switched-capacitor sample memories and a single ADC. A one-cycle trigger, raised when the detector signal crosses a low threshold, starts a capture into whichever memory is next in line. The trigger unit also delivers a pulse class and an anode overflow flag. The class sets the capture length: a long window for multi-photoelectron pulses, or a short window just long enough for one single-photoelectron pulse. The overflow flag picks the analog channel that is later converted: the dynode when the anode saturated, otherwise the anode.

The two memories trade roles. While one records at the fast sample clock, the other is read out to the ADC, one cell per slow transfer strobe. Readout starts at the cell where the capture began and wraps the cell ring. Only captured cells are addressed. Each frame opens with a header word for the packet buffer. A trigger that finds no free memory, or that arrives while a capture is still running, is dropped and counted as dead time.

Top module: `ppseq_top`

## Requirements
- R1: While reset is held and right after it, no memory captures (`cap_we_o` = 0), no header or conversion is issued, and `dead_cnt_o` is 0.
- R2: An accepted trigger makes exactly one bit of `cap_we_o` high from the cycle after the trigger edge, for NSPE_LEN cycles (default 100) when `spe_i`=0 or SPE_LEN cycles (default 20) when `spe_i`=1. At most one memory captures at a time.
- R3: During a capture, `cap_cell_o` advances by one cell per cycle and wraps from CELLS-1 (default 249) to 0. The first capture into a memory after reset starts at cell 0. Each later capture into that memory starts at the cell after its previous capture ended.
- R4: Accepted triggers fill memory 0 first, then alternate between memory 1 and memory 0 (`cap_we_o` bit 0 or bit 1).
- R5: A trigger is dropped when a capture is running or when the next memory has not yet been fully read out. Each dropped trigger raises `dead_cnt_o` by one, saturating at all ones. Any other cycle leaves the counter unchanged.
- R6: On a strobe in which the next memory to read holds a completed capture, a header is issued the cycle after that strobe (`hdr_vld_o` high for one cycle). The header layout is: bit 9 memory index, bit 8 class (1 = single photoelectron), bit 7 channel (1 = dynode), bits 6:0 sample count.
- R7: After the header, each strobe produces exactly one conversion request in the next cycle. The cells run from the capture's start cell, step by one and wrap, for exactly the captured count. `conv_last_o` marks the final request. Without a strobe, no header or conversion is issued.
- R8: `conv_dyn_o` and the header channel bit equal `ovf_i` as sampled with the trigger that started that capture.
- R9: Frames are read out in capture order, memory 0 and 1 alternating (`conv_mem_o`). A memory can accept a new trigger from the cycle after its last conversion. Every accepted capture is read out in full.
- R10: A capture into one memory can proceed while the other memory is being read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | One-cycle threshold trigger |
| spe_i | input | 1 | Pulse class with the trigger, 1 = single photoelectron |
| ovf_i | input | 1 | Anode overflow with the trigger, 1 = convert dynode |
| stb_i | input | 1 | One-cycle readout transfer strobe |
| cap_we_o | output | 2 | Per-memory capture enable |
| cap_cell_o | output | $clog2(CELLS) | Cell being written |
| hdr_vld_o | output | 1 | Header word valid |
| hdr_o | output | 3+$clog2(NSPE_LEN+1) | Header word |
| conv_vld_o | output | 1 | Conversion request valid |
| conv_mem_o | output | 1 | Memory being read |
| conv_cell_o | output | $clog2(CELLS) | Cell being read |
| conv_dyn_o | output | 1 | Channel to convert, 1 = dynode |
| conv_last_o | output | 1 | Final conversion of the frame |
| dead_cnt_o | output | DEAD_W | Dropped-trigger count |

## Verification
Every cycle, the assertions check these invariants: one capture enable at most; capture cells stepping around the ring; headers and conversions appearing only one cycle after a strobe; the dead-time counter changing only on a dropped trigger; and each capture ending in the cycle after its last-sample event. Only the bench scenarios can show the rest: which memory receives each trigger, that a frame restarts at the right cell after the ring wraps, the header fields, the channel choice for each event, capture overlapping readout, and counter saturation. Each of these depends on history spanning several events.

// File: rtl/ppseq_pkg.sv
package ppseq_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_CAP  = 2'd1,
    SLOT_FULL = 2'd2,
    SLOT_READ = 2'd3
  } slot_st_e;

  // next position on a ring of 'cells' entries
  function automatic int unsigned ring_next(int unsigned pos, int unsigned cells);
    return (pos + 1 >= cells) ? 0 : pos + 1;
  endfunction

  // capture length picked from the pulse class
  function automatic int unsigned cap_len(logic spe, int unsigned spe_len,
                                          int unsigned nspe_len);
    return spe ? spe_len : nspe_len;
  endfunction

endpackage

// File: rtl/ppseq_slot.sv
module ppseq_slot #(
  parameter int CELLS = 250,
  parameter int CW    = 8,
  parameter int LW    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [LW-1:0]       len_i,
  input  logic                spe_i,
  input  logic                dyn_i,
  input  logic                rd_start_i,
  input  logic                rd_done_i,
  output ppseq_pkg::slot_st_e st_o,
  output logic                cap_we_o,
  output logic [CW-1:0]       cap_cell_o,
  output logic                cap_last_o,
  output logic [CW-1:0]       base_o,
  output logic [LW-1:0]       len_o,
  output logic                spe_o,
  output logic                dyn_o
);
  import ppseq_pkg::*;

  slot_st_e      st_q;
  logic [CW-1:0] wptr_q;
  logic [CW-1:0] base_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] cnt_q;
  logic          spe_q;
  logic          dyn_q;

  assign cap_last_o = (st_q == SLOT_CAP) && (cnt_q == len_q - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SLOT_IDLE;
      wptr_q <= '0;
      base_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      spe_q  <= 1'b0;
      dyn_q  <= 1'b0;
    end else begin
      case (st_q)
        SLOT_IDLE: if (start_i) begin
          st_q   <= SLOT_CAP;
          base_q <= wptr_q;
          len_q  <= len_i;
          spe_q  <= spe_i;
          dyn_q  <= dyn_i;
          cnt_q  <= '0;
        end
        SLOT_CAP: begin
          wptr_q <= CW'(ring_next(32'(wptr_q), CELLS));
          cnt_q  <= cnt_q + LW'(1);
          if (cap_last_o) st_q <= SLOT_FULL;
        end
        SLOT_FULL: if (rd_start_i) st_q <= SLOT_READ;
        SLOT_READ: if (rd_done_i)  st_q <= SLOT_IDLE;
        default: st_q <= SLOT_IDLE;
      endcase
    end
  end

  assign st_o       = st_q;
  assign cap_we_o   = (st_q == SLOT_CAP);
  assign cap_cell_o = wptr_q;
  assign base_o     = base_q;
  assign len_o      = len_q;
  assign spe_o      = spe_q;
  assign dyn_o      = dyn_q;

endmodule

// File: rtl/ppseq_rdseq.sv
module ppseq_rdseq #(
  parameter int CELLS = 250,
  parameter int CW    = 8,
  parameter int LW    = 7,
  localparam int HW   = 3 + LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic [1:0]    full_i,
  input  logic [CW-1:0] base_i [2],
  input  logic [LW-1:0] len_i  [2],
  input  logic [1:0]    spe_i,
  input  logic [1:0]    dyn_i,
  output logic [1:0]    rd_start_o,
  output logic [1:0]    rd_done_o,
  output logic          hdr_vld_o,
  output logic [HW-1:0] hdr_o,
  output logic          conv_vld_o,
  output logic          conv_mem_o,
  output logic [CW-1:0] conv_cell_o,
  output logic          conv_dyn_o,
  output logic          conv_last_o
);
  import ppseq_pkg::*;

  logic          act_q;
  logic          sel_q;
  logic [CW-1:0] ptr_q;
  logic [LW-1:0] left_q;

  logic open_now, step_now, fin_now;
  assign open_now = stb_i && !act_q && full_i[sel_q];
  assign step_now = stb_i && act_q;
  assign fin_now  = step_now && (left_q == LW'(1));

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      rd_start_o[k] = open_now && (sel_q == 1'(k));
      rd_done_o[k]  = fin_now  && (sel_q == 1'(k));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q       <= 1'b0;
      sel_q       <= 1'b0;
      ptr_q       <= '0;
      left_q      <= '0;
      hdr_vld_o   <= 1'b0;
      hdr_o       <= '0;
      conv_vld_o  <= 1'b0;
      conv_mem_o  <= 1'b0;
      conv_cell_o <= '0;
      conv_dyn_o  <= 1'b0;
      conv_last_o <= 1'b0;
    end else begin
      hdr_vld_o   <= 1'b0;
      conv_vld_o  <= 1'b0;
      conv_last_o <= 1'b0;
      if (open_now) begin
        act_q     <= 1'b1;
        ptr_q     <= base_i[sel_q];
        left_q    <= len_i[sel_q];
        hdr_vld_o <= 1'b1;
        hdr_o     <= {sel_q, spe_i[sel_q], dyn_i[sel_q], len_i[sel_q]};
      end else if (step_now) begin
        conv_vld_o  <= 1'b1;
        conv_mem_o  <= sel_q;
        conv_cell_o <= ptr_q;
        conv_dyn_o  <= dyn_i[sel_q];
        ptr_q       <= CW'(ring_next(32'(ptr_q), CELLS));
        left_q      <= left_q - LW'(1);
        if (fin_now) begin
          conv_last_o <= 1'b1;
          act_q       <= 1'b0;
          sel_q       <= ~sel_q;
        end
      end
    end
  end

endmodule

// File: rtl/ppseq_top.sv
module ppseq_top #(
  parameter int CELLS    = 250,
  parameter int NSPE_LEN = 100,
  parameter int SPE_LEN  = 20,
  parameter int DEAD_W   = 16,
  localparam int CW      = $clog2(CELLS),
  localparam int LW      = $clog2(NSPE_LEN + 1),
  localparam int HW      = 3 + LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              spe_i,
  input  logic              ovf_i,
  input  logic              stb_i,
  output logic [1:0]        cap_we_o,
  output logic [CW-1:0]     cap_cell_o,
  output logic              hdr_vld_o,
  output logic [HW-1:0]     hdr_o,
  output logic              conv_vld_o,
  output logic              conv_mem_o,
  output logic [CW-1:0]     conv_cell_o,
  output logic              conv_dyn_o,
  output logic              conv_last_o,
  output logic [DEAD_W-1:0] dead_cnt_o
);
  import ppseq_pkg::*;

  slot_st_e      slot_st   [2];
  logic [CW-1:0] slot_cell [2];
  logic [CW-1:0] slot_base [2];
  logic [LW-1:0] slot_len  [2];
  logic [1:0]    slot_spe, slot_dyn, slot_full;
  logic [1:0]    rd_start, rd_done;

  // named internal events
  logic [1:0]    cap_last;
  logic          cap_busy, accept, trig_drop;
  logic          cap_sel_q;
  logic [LW-1:0] len_pick;

  assign cap_busy  = |cap_we_o;
  assign accept    = trig_i && !cap_busy && (slot_st[cap_sel_q] == SLOT_IDLE);
  assign trig_drop = trig_i && !accept;
  assign len_pick  = LW'(cap_len(spe_i, SPE_LEN, NSPE_LEN));

  for (genvar k = 0; k < 2; k++) begin : g_slot
    ppseq_slot #(.CELLS(CELLS), .CW(CW), .LW(LW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (accept && (cap_sel_q == 1'(k))),
      .len_i      (len_pick),
      .spe_i      (spe_i),
      .dyn_i      (ovf_i),
      .rd_start_i (rd_start[k]),
      .rd_done_i  (rd_done[k]),
      .st_o       (slot_st[k]),
      .cap_we_o   (cap_we_o[k]),
      .cap_cell_o (slot_cell[k]),
      .cap_last_o (cap_last[k]),
      .base_o     (slot_base[k]),
      .len_o      (slot_len[k]),
      .spe_o      (slot_spe[k]),
      .dyn_o      (slot_dyn[k])
    );
    assign slot_full[k] = (slot_st[k] == SLOT_FULL);
  end

  assign cap_cell_o = cap_we_o[1] ? slot_cell[1] : slot_cell[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_sel_q  <= 1'b0;
      dead_cnt_o <= '0;
    end else begin
      if (accept) cap_sel_q <= ~cap_sel_q;
      if (trig_drop && (dead_cnt_o != '1)) dead_cnt_o <= dead_cnt_o + DEAD_W'(1);
    end
  end

  ppseq_rdseq #(.CELLS(CELLS), .CW(CW), .LW(LW)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb_i       (stb_i),
    .full_i      (slot_full),
    .base_i      (slot_base),
    .len_i       (slot_len),
    .spe_i       (slot_spe),
    .dyn_i       (slot_dyn),
    .rd_start_o  (rd_start),
    .rd_done_o   (rd_done),
    .hdr_vld_o   (hdr_vld_o),
    .hdr_o       (hdr_o),
    .conv_vld_o  (conv_vld_o),
    .conv_mem_o  (conv_mem_o),
    .conv_cell_o (conv_cell_o),
    .conv_dyn_o  (conv_dyn_o),
    .conv_last_o (conv_last_o)
  );

endmodule

// File: rtl/ppseq_chk.sv
module ppseq_chk #(
  parameter int CELLS  = 250,
  parameter int CW     = 8,
  parameter int DEAD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stb_i,
  input logic [1:0]        cap_we_o,
  input logic [CW-1:0]     cap_cell_o,
  input logic              hdr_vld_o,
  input logic              conv_vld_o,
  input logic              conv_last_o,
  input logic [DEAD_W-1:0] dead_cnt_o,
  input logic              trig_drop,
  input logic [1:0]        cap_last
);

  // R2
  cap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_we_o));

  // R2
  cap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap_last) |=> ((cap_we_o & $past(cap_last)) == 2'b00));

  // R3
  cap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cap_we_o) && (cap_we_o == $past(cap_we_o))) |->
      (cap_cell_o == CW'(ppseq_pkg::ring_next(32'($past(cap_cell_o)), CELLS))));

  // R6
  hdr_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld_o |-> ($past(stb_i) && !conv_vld_o));

  // R7
  conv_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_vld_o |-> $past(stb_i));

  // R7
  last_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_last_o |-> conv_vld_o);

  // R5
  dead_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_drop && (dead_cnt_o != '1)) |=> (dead_cnt_o == $past(dead_cnt_o) + DEAD_W'(1)));

  // R5
  dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_drop |=> $stable(dead_cnt_o));

endmodule

bind ppseq_top ppseq_chk #(.CELLS(CELLS), .CW(CW), .DEAD_W(DEAD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stb_i       (stb_i),
  .cap_we_o    (cap_we_o),
  .cap_cell_o  (cap_cell_o),
  .hdr_vld_o   (hdr_vld_o),
  .conv_vld_o  (conv_vld_o),
  .conv_last_o (conv_last_o),
  .dead_cnt_o  (dead_cnt_o),
  .trig_drop   (trig_drop),
  .cap_last    (cap_last)
);

// File: tb/ppseq_top_tb_top.sv
module ppseq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CELLS      = 250;
  localparam int NSPE       = 100;
  localparam int SPE        = 20;
  localparam int DW         = 4;
  localparam int STB_DIV    = 10;
  localparam int NV         = 7;
  // {spe, ovf, idle cycles before trigger}
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b0, 12'd5},
    {1'b1, 1'b1, 12'd30},
    {1'b1, 1'b1, 12'd120},
    {1'b0, 1'b0, 12'd30},
    {1'b0, 1'b1, 12'd1500},
    {1'b1, 1'b0, 12'd1200},
    {1'b0, 1'b1, 12'd1200}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_i = 1'b0, spe_i = 1'b0, ovf_i = 1'b0, stb_i = 1'b0;
  logic [1:0] cap_we_o;
  logic [7:0] cap_cell_o, conv_cell_o;
  logic hdr_vld_o, conv_vld_o, conv_mem_o, conv_dyn_o, conv_last_o;
  logic [9:0] hdr_o;
  logic [DW-1:0] dead_cnt_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppseq_top #(.CELLS(CELLS), .NSPE_LEN(NSPE), .SPE_LEN(SPE), .DEAD_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .spe_i(spe_i), .ovf_i(ovf_i),
    .stb_i(stb_i), .cap_we_o(cap_we_o), .cap_cell_o(cap_cell_o),
    .hdr_vld_o(hdr_vld_o), .hdr_o(hdr_o), .conv_vld_o(conv_vld_o),
    .conv_mem_o(conv_mem_o), .conv_cell_o(conv_cell_o), .conv_dyn_o(conv_dyn_o),
    .conv_last_o(conv_last_o), .dead_cnt_o(dead_cnt_o));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  // bench model
  int cap_left, cap_mem, cap_cell, next_cap, rd_sel, rd_ptr, rd_left, stb_cnt;
  int nxt_start [2], base_m [2], len_m [2];
  bit busy [2], ready [2], spe_m [2], dyn_m [2];
  bit cap_fin, cap_vis, rd_act;
  bit e_hdr, e_conv, e_last, e_dyn;
  int e_cell, e_mem, exp_dead, frames_exp, frames_done, overlap;
  logic [9:0] e_hdr_val;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_init();
    cap_left = 0; cap_mem = 0; cap_cell = 0; next_cap = 0; rd_sel = 0;
    rd_ptr = 0; rd_left = 0; stb_cnt = 0; cap_fin = 0; cap_vis = 0; rd_act = 0;
    e_hdr = 0; e_conv = 0; e_last = 0; e_dyn = 0; e_cell = 0; e_mem = 0;
    exp_dead = 0; frames_exp = 0; frames_done = 0; overlap = 0;
    for (int k = 0; k < 2; k++) begin
      nxt_start[k] = 0; base_m[k] = 0; len_m[k] = 0;
      busy[k] = 0; ready[k] = 0; spe_m[k] = 0; dyn_m[k] = 0;
    end
  endtask

  task automatic check_outputs();
    if (cap_fin) begin ready[cap_mem] = 1; cap_fin = 0; end
    cap_vis = (cap_left > 0);
    if (cap_vis) begin
      chk(cap_we_o == 2'(1 << cap_mem), "R4", "capture memory", int'(cap_we_o), 1 << cap_mem);
      chk(int'(cap_cell_o) == cap_cell, "R3", "capture cell", int'(cap_cell_o), cap_cell);
      cap_cell = (cap_cell + 1) % CELLS;
      cap_left--;
      if (cap_left == 0) cap_fin = 1;
      if (conv_vld_o) overlap++;
    end else begin
      chk(cap_we_o == 2'b00, "R2", "capture idle", int'(cap_we_o), 0);
    end
    chk(hdr_vld_o == e_hdr, "R6", "header valid", int'(hdr_vld_o), int'(e_hdr));
    if (e_hdr) chk(hdr_o == e_hdr_val, "R6", "header word", int'(hdr_o), int'(e_hdr_val));
    chk(conv_vld_o == e_conv, "R7", "conversion valid", int'(conv_vld_o), int'(e_conv));
    if (e_conv) begin
      chk(int'(conv_cell_o) == e_cell, "R7", "read cell", int'(conv_cell_o), e_cell);
      chk(int'(conv_mem_o) == e_mem, "R9", "read memory", int'(conv_mem_o), e_mem);
      chk(conv_dyn_o == e_dyn, "R8", "channel select", int'(conv_dyn_o), int'(e_dyn));
      chk(conv_last_o == e_last, "R7", "last flag", int'(conv_last_o), int'(e_last));
      if (e_last) begin busy[e_mem] = 0; frames_done++; end
    end
    e_hdr = 0; e_conv = 0;
  endtask

  task automatic step(bit trig, bit spe, bit ovf);
    bit stb;
    @(negedge clk);
    check_outputs();
    stb = (stb_cnt == STB_DIV - 1);
    stb_cnt = (stb_cnt + 1) % STB_DIV;
    if (stb) begin
      if (!rd_act && ready[rd_sel]) begin
        e_hdr = 1;
        e_hdr_val = {rd_sel[0], spe_m[rd_sel], dyn_m[rd_sel], 7'(len_m[rd_sel])};
        rd_act = 1; rd_ptr = base_m[rd_sel]; rd_left = len_m[rd_sel];
        ready[rd_sel] = 0;
      end else if (rd_act) begin
        e_conv = 1; e_cell = rd_ptr; e_mem = rd_sel; e_dyn = dyn_m[rd_sel];
        e_last = (rd_left == 1);
        rd_ptr = (rd_ptr + 1) % CELLS;
        rd_left--;
        if (rd_left == 0) begin rd_act = 0; rd_sel ^= 1; end
      end
    end
    if (trig) begin
      if (!cap_vis && !busy[next_cap]) begin
        cap_mem = next_cap; cap_left = spe ? SPE : NSPE; cap_cell = nxt_start[next_cap];
        base_m[next_cap] = cap_cell; len_m[next_cap] = cap_left;
        spe_m[next_cap] = spe; dyn_m[next_cap] = ovf; busy[next_cap] = 1;
        nxt_start[next_cap] = (cap_cell + cap_left) % CELLS;
        next_cap ^= 1; frames_exp++;
      end else if (exp_dead < (1 << DW) - 1) exp_dead++;
    end
    stb_i = stb; trig_i = trig; spe_i = spe; ovf_i = ovf;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; trig_i = 0; stb_i = 0; spe_i = 0; ovf_i = 0;
    repeat (3) @(negedge clk);
    // R1: idle outputs while reset is held
    chk(cap_we_o == 2'b00, "R1", "cap_we in reset", int'(cap_we_o), 0);
    chk(!hdr_vld_o && !conv_vld_o, "R1", "hdr/conv in reset", int'({hdr_vld_o, conv_vld_o}), 0);
    chk(dead_cnt_o == '0, "R1", "dead count in reset", int'(dead_cnt_o), 0);
    model_init();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(0, 0, 0);
    chk(dead_cnt_o == '0, "R1", "dead count after reset", int'(dead_cnt_o), 0);
    // table-driven scenario
    for (int i = 0; i < NV; i++) begin
      repeat (int'(VEC[i][11:0])) step(0, 0, 0);
      step(1, VEC[i][13], VEC[i][12]);
      step(0, 0, 0);
      chk(int'(dead_cnt_o) == exp_dead, "R5", "dead count", int'(dead_cnt_o), exp_dead);
    end
    repeat (2500) step(0, 0, 0);
    chk(frames_done == frames_exp, "R9", "frames completed", frames_done, frames_exp);
    chk(frames_exp == 5, "R4", "accepted triggers", frames_exp, 5);
    chk(overlap > 0, "R10", "capture during readout", overlap, 1);
    // saturation of the dead-time counter
    do_reset();
    step(0, 0, 0);
    step(1, 0, 0);
    repeat (20) step(1, 1, 0);
    step(0, 0, 0);
    chk(int'(dead_cnt_o) == (1 << DW) - 1, "R5", "saturated dead count", int'(dead_cnt_o), (1 << DW) - 1);
    // reset in the middle of a capture
    repeat (10) step(0, 0, 0);
    do_reset();
    step(0, 0, 0);
    chk(cap_we_o == 2'b00 && dead_cnt_o == '0, "R1", "state after mid-run reset",
        int'({cap_we_o, dead_cnt_o}), 0);
    // first capture after reset starts at cell 0 on memory 0
    step(1, 1, 1);
    repeat (400) step(0, 0, 0);
    chk(frames_done == 1, "R2", "single frame after reset", frames_done, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule